// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block decides where each received network frame lands in a local buffer memory. The memory is treated as a ring of fixed-size pages lying between a programmable first page and a programmable end page (exclusive). Frame bytes arrive one per cycle from a receive engine. The block turns them into memory writes, moving on to the next page whenever a page fills and returning to the first page of the ring after the last one.

Each frame starts at the current page. Its data begins four bytes into that page, so that a four-byte status header can be written in front of it once the frame has ended and its length and outcome are known. A good frame moves the current page past the pages it used and raises a one-cycle completion pulse. A frame flagged bad at its end is dropped without a header and without moving the current page, so the next frame reuses the same space. If storing a frame would spill into the page the host has not yet released (the boundary page), the rest of that frame is discarded and a sticky overflow flag is raised. Frames already stored stay intact.

Top module: `ring_rx_mgr`

## Requirements
- R1: While rst_n is low at a clock edge, curPage takes the value of ringStart, and memWe, pktDone and ovfFlag are 0 afterwards.
- R2: After rxStart, the n-th data byte (rxValid high) of a frame is written to offset 4+n-1 of the frame's first page (curPage). memWe is high in the cycle after the byte is presented, with memAddr = {page, offset} and memData = byte.
- R3: The byte after the one written at the last offset of a page (all offset bits 1) goes to offset 0 of the following page.
- R4: The page following page p is p+1, except that when p+1 equals ringStop the following page is ringStart.
- R5: After rxEnd with rxBad low, four header writes follow at offsets 0, 1, 2 and 3 of the frame's first page, in that order. Their contents are the rxStatus byte sampled with rxEnd, the next page (R6), and the low and then high byte of the 16-bit count, which is the number of data bytes plus 4.
- R6: After those header writes, curPage becomes the page following the last page that holds frame data. If the last byte was written at a page's last offset, it becomes the page that was linked to. pktDone is high for exactly one cycle, in the same cycle as the last header write.
- R7: A frame ended with rxBad high gets no header and no pktDone, and curPage is left unchanged.
- R8: When a byte written at a page's last offset would link to the page equal to hostBound, that byte is the frame's last write. Later bytes, the header and pktDone are suppressed, curPage is unchanged and ovfFlag is set.
- R9: ovfFlag stays set until a cycle with ovfClear high, and is then 0 unless a new overflow occurs in that cycle.
- R10: rxValid outside a frame, and rxStart inside a frame, cause no memory write and no change to the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ringStart | input | PAGE_W | First page of the ring |
| ringStop | input | PAGE_W | Page one past the last page of the ring |
| hostBound | input | PAGE_W | Page not yet released by the host |
| rxStart | input | 1 | Frame start pulse (no data) |
| rxValid | input | 1 | rxData holds a frame byte |
| rxData | input | 8 | Frame byte |
| rxEnd | input | 1 | Frame end pulse, never together with rxValid |
| rxBad | input | 1 | With rxEnd: frame rejected (runt, CRC or alignment) |
| rxStatus | input | 8 | With rxEnd: status byte for the header |
| ovfClear | input | 1 | Clears the overflow flag |
| memAddr | output | PAGE_W+OFFS_W | Memory write address {page, offset} |
| memData | output | 8 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| curPage | output | PAGE_W | Current page where the next frame starts |
| pktDone | output | 1 | One-cycle good-frame completion pulse |
| ovfFlag | output | 1 | Sticky overflow indication |

## Verification
The bench builds the block with PAGE_W = 8 and OFFS_W = 4, which gives 16-byte pages, over a four-page ring from page 4 to page 7. With pages this short, frames of a few dozen bytes cross page links, wrap from the last ring page back to the first, and fill a page exactly to its last offset. It also lets a boundary page one link ahead force an overflow abort within a dozen bytes. The data, header bytes and next-page field of every frame are predicted by a reference model of the ring and compared write by write.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  // strobes from the control FSM to the pointer datapath
  typedef struct packed {
    logic       frameLoad;   // a new frame begins at curPage
    logic       byteTake;    // store the presented byte
    logic       ovfSet;      // boundary reached, frame aborted
    logic       statusLatch; // good end: capture status byte
    logic       hdrWrite;    // emit one header byte
    logic [1:0] hdrIdx;      // which header byte
    logic       commit;      // last header byte, advance curPage
  } rbmCtl_t;
endpackage

// File: rtl/rbm_ctrl.sv
module rbm_ctrl
  import rbm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rxStart,
  input  logic    rxValid,
  input  logic    rxEnd,
  input  logic    rxBad,
  input  logic    linkHit,
  output rbmCtl_t ctl
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_DROP, ST_HDR} rbmState_t;

  rbmState_t state, stateNx;
  logic [1:0] hdrCnt;

  always_comb begin
    ctl     = '0;
    stateNx = state;
    case (state)
      ST_IDLE: begin
        if (rxStart) begin
          ctl.frameLoad = 1'b1;
          stateNx       = ST_DATA;
        end
      end
      ST_DATA: begin
        if (rxEnd) begin
          if (rxBad) begin
            stateNx = ST_IDLE;           // rollback: curPage untouched
          end else begin
            ctl.statusLatch = 1'b1;
            stateNx         = ST_HDR;
          end
        end else if (rxValid) begin
          ctl.byteTake = 1'b1;
          if (linkHit) begin
            ctl.ovfSet = 1'b1;
            stateNx    = ST_DROP;
          end
        end
      end
      ST_DROP: begin
        if (rxEnd) stateNx = ST_IDLE;
      end
      ST_HDR: begin
        ctl.hdrWrite = 1'b1;
        ctl.hdrIdx   = hdrCnt;
        if (hdrCnt == 2'd3) begin
          ctl.commit = 1'b1;
          stateNx    = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      hdrCnt <= 2'd0;
    end else begin
      state  <= stateNx;
      hdrCnt <= (state == ST_HDR) ? hdrCnt + 2'd1 : 2'd0;
    end
  end
endmodule

// File: rtl/rbm_dpath.sv
module rbm_dpath
  import rbm_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  rbmCtl_t                  ctl,
  input  logic [7:0]               rxData,
  input  logic [7:0]               rxStatus,
  input  logic                     ovfClear,
  input  logic [PAGE_W-1:0]        ringStart,
  input  logic [PAGE_W-1:0]        ringStop,
  input  logic [PAGE_W-1:0]        hostBound,
  output logic                     linkHit,
  output logic [PAGE_W+OFFS_W-1:0] memAddr,
  output logic [7:0]               memData,
  output logic                     memWe,
  output logic [PAGE_W-1:0]        curPage,
  output logic                     pktDone,
  output logic                     ovfFlag
);
  localparam int CNT_W = 16;
  localparam logic [OFFS_W-1:0] LAST_OFF = '1;
  localparam logic [OFFS_W-1:0] DATA_OFF = OFFS_W'(4);
  localparam logic [CNT_W-1:0]  HDR_LEN  = CNT_W'(4);

  logic [PAGE_W-1:0] firstPage, wrPage;
  logic [OFFS_W-1:0] wrOff;
  logic [CNT_W-1:0]  byteCnt;
  logic [7:0]        statusReg;

  logic [PAGE_W-1:0] wrInc, wrNext, endNext;
  logic [7:0]        hdrByte;

  // ring successor of the page being written
  always_comb begin
    wrInc   = wrPage + PAGE_W'(1);
    wrNext  = (wrInc == ringStop) ? ringStart : wrInc;
    linkHit = (wrOff == LAST_OFF) && (wrNext == hostBound);
    endNext = (wrOff == '0) ? wrPage : wrNext;
    case (ctl.hdrIdx)
      2'd0:    hdrByte = statusReg;
      2'd1:    hdrByte = 8'(endNext);
      2'd2:    hdrByte = byteCnt[7:0];
      default: hdrByte = byteCnt[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curPage   <= ringStart;
      firstPage <= '0;
      wrPage    <= '0;
      wrOff     <= '0;
      byteCnt   <= '0;
      statusReg <= '0;
      memAddr   <= '0;
      memData   <= '0;
      memWe     <= 1'b0;
      pktDone   <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      memWe   <= 1'b0;
      pktDone <= ctl.commit;
      if (ctl.frameLoad) begin
        firstPage <= curPage;
        wrPage    <= curPage;
        wrOff     <= DATA_OFF;
        byteCnt   <= HDR_LEN;
      end
      if (ctl.byteTake) begin
        memAddr <= {wrPage, wrOff};
        memData <= rxData;
        memWe   <= 1'b1;
        byteCnt <= byteCnt + CNT_W'(1);
        if (wrOff == LAST_OFF) begin
          wrPage <= wrNext;
          wrOff  <= '0;
        end else begin
          wrOff <= wrOff + OFFS_W'(1);
        end
      end
      if (ctl.statusLatch) statusReg <= rxStatus;
      if (ctl.hdrWrite) begin
        memAddr <= {firstPage, OFFS_W'(ctl.hdrIdx)};
        memData <= hdrByte;
        memWe   <= 1'b1;
      end
      if (ctl.commit) curPage <= endNext;
      if (ctl.ovfSet)     ovfFlag <= 1'b1;
      else if (ovfClear)  ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_rx_mgr.sv
module ring_rx_mgr
  import rbm_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFFS_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PAGE_W-1:0]        ringStart,
  input  logic [PAGE_W-1:0]        ringStop,
  input  logic [PAGE_W-1:0]        hostBound,
  input  logic                     rxStart,
  input  logic                     rxValid,
  input  logic [7:0]               rxData,
  input  logic                     rxEnd,
  input  logic                     rxBad,
  input  logic [7:0]               rxStatus,
  input  logic                     ovfClear,
  output logic [PAGE_W+OFFS_W-1:0] memAddr,
  output logic [7:0]               memData,
  output logic                     memWe,
  output logic [PAGE_W-1:0]        curPage,
  output logic                     pktDone,
  output logic                     ovfFlag
);
  rbmCtl_t ctl;
  logic    linkHit;

  rbm_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxStart (rxStart),
    .rxValid (rxValid),
    .rxEnd   (rxEnd),
    .rxBad   (rxBad),
    .linkHit (linkHit),
    .ctl     (ctl)
  );

  rbm_dpath #(.PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) dpath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .rxData    (rxData),
    .rxStatus  (rxStatus),
    .ovfClear  (ovfClear),
    .ringStart (ringStart),
    .ringStop  (ringStop),
    .hostBound (hostBound),
    .linkHit   (linkHit),
    .memAddr   (memAddr),
    .memData   (memData),
    .memWe     (memWe),
    .curPage   (curPage),
    .pktDone   (pktDone),
    .ovfFlag   (ovfFlag)
  );
endmodule

// File: rtl/rbm_chk.sv
module rbm_chk #(
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PAGE_W-1:0] ringStart,
  input logic [PAGE_W-1:0] ringStop,
  input logic              ovfClear,
  input logic [PAGE_W-1:0] memPage,
  input logic              memWe,
  input logic [PAGE_W-1:0] curPage,
  input logic              pktDone,
  input logic              ovfFlag
);
  AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> (memPage >= ringStart && memPage < ringStop)); // R4

  AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (curPage >= ringStart && curPage < ringStop)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pktDone |=> !pktDone); // R6

  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pktDone |-> memWe); // R5

  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !pktDone) |-> $stable(curPage)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !ovfClear) |=> ovfFlag); // R9
endmodule

bind ring_rx_mgr rbm_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ringStart (ringStart),
  .ringStop  (ringStop),
  .ovfClear  (ovfClear),
  .memPage   (memAddr[PAGE_W+OFFS_W-1:OFFS_W]),
  .memWe     (memWe),
  .curPage   (curPage),
  .pktDone   (pktDone),
  .ovfFlag   (ovfFlag)
);

// File: tb/ring_rx_mgr_tb.sv
module ring_rx_mgr_tb_top;
  localparam int PW = 8;
  localparam int OW = 4;
  localparam int PS = 1 << OW;
  localparam logic [PW-1:0] START = 8'd4;
  localparam logic [PW-1:0] STOP  = 8'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] hostBound = 8'd0;
  logic rxStart = 0, rxValid = 0, rxEnd = 0, rxBad = 0, ovfClear = 0;
  logic [7:0] rxData = 0, rxStatus = 0;
  logic [PW+OW-1:0] memAddr;
  logic [7:0] memData;
  logic memWe, pktDone, ovfFlag;
  logic [PW-1:0] curPage;

  always #10 clk = ~clk;

  ring_rx_mgr #(.PAGE_W(PW), .OFFS_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ringStart(START), .ringStop(STOP),
    .hostBound(hostBound), .rxStart(rxStart), .rxValid(rxValid),
    .rxData(rxData), .rxEnd(rxEnd), .rxBad(rxBad), .rxStatus(rxStatus),
    .ovfClear(ovfClear), .memAddr(memAddr), .memData(memData),
    .memWe(memWe), .curPage(curPage), .pktDone(pktDone), .ovfFlag(ovfFlag)
  );

  int checks = 0;
  int errors = 0;
  int writesSeen = 0;
  int doneSeen = 0;
  int doneExp = 0;
  bit finished = 0;
  logic [PW+OW+7:0] expQ[$];
  string tagQ[$];
  logic [PW-1:0] curM = START;
  logic ovfM = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    logic [PW-1:0] q = p + 8'd1;
    return (q == STOP) ? START : q;
  endfunction

  task automatic pushExp(input logic [PW-1:0] pg, input int off, input logic [7:0] d, input string tag);
    expQ.push_back({pg, OW'(off), d});
    tagQ.push_back(tag);
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst_n && memWe) begin
      writesSeen++;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected write actual=%0h expected=none", {memAddr, memData});
      end else begin
        logic [PW+OW+7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, 32'({memAddr, memData}), 32'(e));
      end
    end
    if (rst_n && pktDone) doneSeen++;
  end

  // driver: one frame, expected writes pushed to the scoreboard
  task automatic frame(input int n, input bit bad, input logic [7:0] st,
                       input logic [7:0] seed, input bit strayStart, input string tg);
    logic [PW-1:0] pg, first, np;
    int off, cnt;
    bit ab;
    pg = curM; first = curM; off = 4; cnt = 4; ab = 0;
    @(posedge clk); #1 rxStart = 1;
    @(posedge clk); #1 rxStart = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i);
      if (strayStart && i == 3) begin
        rxStart = 1; @(posedge clk); #1 rxStart = 0;
      end
      if (!ab) begin
        pushExp(pg, off, d, tg);
        cnt++;
        if (off == PS - 1) begin
          np = nxt(pg);
          if (np == hostBound) ab = 1;
          pg = np; off = 0;
        end else off++;
      end
      rxValid = 1; rxData = d;
      @(posedge clk); #1 rxValid = 0;
    end
    rxEnd = 1; rxBad = bad; rxStatus = st;
    @(posedge clk); #1 rxEnd = 0; rxBad = 0;
    if (ab) ovfM = 1'b1;
    else if (!bad) begin
      np = (off == 0) ? pg : nxt(pg);
      pushExp(first, 0, st, "R5 status");
      pushExp(first, 1, 8'(np), "R5 next page");
      pushExp(first, 2, 8'(cnt), "R5 count low");
      pushExp(first, 3, 8'(cnt >> 8), "R5 count high");
      curM = np;
      doneExp++;
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk({tg, " curPage R6"}, 32'(curPage), 32'(curM));
    chk({tg, " ovfFlag R8"}, 32'(ovfFlag), 32'(ovfM));
    chk({tg, " pktDone count R6"}, 32'(doneSeen), 32'(doneExp));
    chk({tg, " pending writes"}, 32'(expQ.size()), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 memWe", 32'(memWe), 32'd0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 curPage", 32'(curPage), 32'(START));
    chk("R1 pktDone", 32'(pktDone), 32'd0);
    chk("R1 ovfFlag", 32'(ovfFlag), 32'd0);

    // R10: bytes outside a frame are ignored
    w0 = writesSeen;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      rxValid = 1; rxData = 8'hA0 + 8'(i); @(posedge clk); #1;
    end
    rxValid = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10 idle bytes no write", 32'(writesSeen - w0), 32'd0);
    chk("R10 idle curPage", 32'(curPage), 32'(START));

    frame(10, 0, 8'h21, 8'h10, 0, "R2 single page");
    frame(30, 0, 8'h22, 8'h40, 0, "R3 three pages");
    frame(12, 0, 8'h23, 8'h80, 0, "R6 exact fill");
    frame(20, 0, 8'h24, 8'hC0, 0, "R3 two pages");
    frame(20, 0, 8'h25, 8'h05, 0, "R4 link wrap");
    frame(15, 1, 8'h26, 8'h30, 0, "R7 rejected");
    frame(6, 0, 8'h27, 8'h60, 1, "R10 stray start");
    hostBound = 8'd7;
    frame(20, 0, 8'h28, 8'h90, 0, "R8 overflow");
    hostBound = 8'd0;
    frame(3, 0, 8'h29, 8'hE0, 0, "R9 sticky");
    @(posedge clk); #1 ovfClear = 1;
    @(posedge clk); #1 ovfClear = 0;
    ovfM = 1'b0;
    @(negedge clk);
    chk("R9 cleared", 32'(ovfFlag), 32'd0);
    frame(5, 0, 8'h2A, 8'h11, 0, "R2 after clear");
    finish_run();
  end
endmodule